// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block brings a two-wire bus back to an idle state before the master engine is allowed to use it. A single start strobe launches a recovery run. The run first emits a one-cycle pulse that clears the sticky status and error flags by write-one. It holds the transfer engine in soft reset for the whole run. It then checks the levels on the data and clock lines. The bus is idle only when both lines read high. When the bus is not idle, the block toggles the clock line to shake loose a device that is still holding data low. It drives the clock low, releases it, and samples again. This repeats until the bus reads idle or a fixed number of attempts is spent.

Each clock-low phase and each clock-high phase lasts a programmable number of ticks from an external bit-period timer. The data line is never pulled low by this block, so a run cannot produce a false start condition. At the end the soft reset drops in the same cycle as one result flag rises: done if the bus came free, fail if it did not. The result flag stays set until the next run is accepted.

Top module: `bus_recovery_seq`

## Requirements
- R1: A high `startReq` while no run is active starts a run. In the next cycle `flagClear` is high for exactly one cycle and `engineReset` is high. A `startReq` during an active run is ignored: it causes no second `flagClear` pulse and no change in the pulse count.
- R2: `engineReset` stays high for the whole run. It falls at the same clock edge at which `done` or `fail` is set, and it is low when no run is active, including after reset.
- R3: The bus counts as free only when `sdaIn` and `sclIn` are both 1. If the bus is free at the first sample, the run ends with `done`=1 and no clock pulse is issued.
- R4: At the start of a run both line drivers are released: `sclDriveLow`=0 and `sdaDriveLow`=0 in the cycle in which `flagClear` is high.
- R5: Each attempt samples the lines. If the bus is not free, the attempt drives `sclDriveLow`=1 for exactly `phaseTicks` cycles with `tickIn` high, then releases it for `phaseTicks` ticks, then samples again. A `phaseTicks` of 0 acts as 1.
- R6: At most MAX_ATTEMPTS clock pulses (default 100) are issued. If the bus is still not free at the sample after the last pulse, the run ends with `fail`=1 and `done`=0.
- R7: `done` and `fail` are 0 after reset and never 1 together. They hold their value until the next accepted start, which clears them.
- R8: `sdaDriveLow` is never 1.
- R9: A clock line held low by another device is recovered in the same way as a stuck data line. The run ends with `done` once both lines read high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start strobe for a recovery run |
| tickIn | input | 1 | One-cycle pulse from the bit-period timer |
| phaseTicks | input | TICK_W | Ticks per clock-low and per clock-high phase (0 acts as 1) |
| sdaIn | input | 1 | Sampled level of the data line |
| sclIn | input | 1 | Sampled level of the clock line |
| sdaDriveLow | output | 1 | Open-drain pull-down enable for the data line |
| sclDriveLow | output | 1 | Open-drain pull-down enable for the clock line |
| flagClear | output | 1 | One-cycle write-one pulse clearing the sticky status and error flags |
| engineReset | output | 1 | Soft reset to the master transfer engine |
| done | output | 1 | Run ended with the bus free |
| fail | output | 1 | Run ended with the bus still held after the last attempt |

## Verification
The assertions assume that `sdaIn` and `sclIn` are already synchronous to `clk`. The clock-pulse and done properties relate line levels in the cycle before an edge to what the design decides at that edge, so they also assume that the line levels are stable across each clock edge. The bench follows both assumptions. It builds the line levels from the block's own drive outputs and from a bus model that changes only at the falling clock edge. It drives `tickIn` with a clocked generator, so every level the design samples was settled half a cycle earlier.

// File: rtl/bus_recovery_pkg.sv
package bus_recovery_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_SAMPLE,
    ST_LOW,
    ST_HIGH
  } recState_t;

  // Strobes from the sequencer to the datapath, one cycle each.
  typedef struct packed {
    logic runStart;    // clear result flags and attempt counter
    logic phaseLoad;   // restart the per-phase tick counter
    logic attemptInc;  // one clock pulse completed
    logic sclPull;     // begin the clock-low phase
    logic sclRelease;  // end the clock-low phase
    logic markDone;    // bus read free
    logic markFail;    // attempts exhausted
  } recStrobes_t;

endpackage

// File: rtl/bus_recovery_dp.sv
module bus_recovery_dp
  import bus_recovery_pkg::*;
#(
  parameter int MAX_ATTEMPTS = 100,
  parameter int TICK_W       = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  recStrobes_t       strb,
  input  logic              tickIn,
  input  logic [TICK_W-1:0] phaseTicks,
  input  logic              sdaIn,
  input  logic              sclIn,
  output logic              busFree,
  output logic              phaseDone,
  output logic              attemptsSpent,
  output logic              sclLow,
  output logic              doneQ,
  output logic              failQ
);

  localparam int ATT_W = $clog2(MAX_ATTEMPTS + 1);

  logic [TICK_W-1:0] phaseCnt;
  logic [TICK_W-1:0] effTicks;
  logic [ATT_W-1:0]  attemptCnt;

  assign busFree  = sdaIn & sclIn;
  assign effTicks = (phaseTicks == '0) ? TICK_W'(1) : phaseTicks;

  // The phase ends on the tick that brings the count up to effTicks.
  assign phaseDone = tickIn &&
    (({1'b0, phaseCnt} + (TICK_W+1)'(1)) >= {1'b0, effTicks});

  assign attemptsSpent = (attemptCnt == ATT_W'(MAX_ATTEMPTS));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseCnt <= '0;
    end else if (strb.phaseLoad) begin
      phaseCnt <= '0;
    end else if (tickIn) begin
      phaseCnt <= phaseCnt + TICK_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      attemptCnt <= '0;
    end else if (strb.runStart) begin
      attemptCnt <= '0;
    end else if (strb.attemptInc) begin
      attemptCnt <= attemptCnt + ATT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclLow <= 1'b0;
    end else if (strb.runStart || strb.sclRelease) begin
      sclLow <= 1'b0;
    end else if (strb.sclPull) begin
      sclLow <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneQ <= 1'b0;
      failQ <= 1'b0;
    end else if (strb.runStart) begin
      doneQ <= 1'b0;
      failQ <= 1'b0;
    end else begin
      if (strb.markDone) doneQ <= 1'b1;
      if (strb.markFail) failQ <= 1'b1;
    end
  end

endmodule

// File: rtl/bus_recovery_ctrl.sv
module bus_recovery_ctrl
  import bus_recovery_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        busFree,
  input  logic        phaseDone,
  input  logic        attemptsSpent,
  output recStrobes_t strb,
  output logic        flagClear,
  output logic        engineReset
);

  recState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          strb.runStart = 1'b1;
          stateNext     = ST_CLEAR;
        end
      end
      ST_CLEAR: begin
        stateNext = ST_SAMPLE;
      end
      ST_SAMPLE: begin
        if (busFree) begin
          strb.markDone = 1'b1;
          stateNext     = ST_IDLE;
        end else if (attemptsSpent) begin
          strb.markFail = 1'b1;
          stateNext     = ST_IDLE;
        end else begin
          strb.sclPull   = 1'b1;
          strb.phaseLoad = 1'b1;
          stateNext      = ST_LOW;
        end
      end
      ST_LOW: begin
        if (phaseDone) begin
          strb.sclRelease = 1'b1;
          strb.phaseLoad  = 1'b1;
          stateNext       = ST_HIGH;
        end
      end
      ST_HIGH: begin
        if (phaseDone) begin
          strb.attemptInc = 1'b1;
          stateNext       = ST_SAMPLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign flagClear   = (state == ST_CLEAR);
  assign engineReset = (state != ST_IDLE);

endmodule

// File: rtl/bus_recovery_seq.sv
module bus_recovery_seq
  import bus_recovery_pkg::*;
#(
  parameter int MAX_ATTEMPTS = 100,
  parameter int TICK_W       = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              tickIn,
  input  logic [TICK_W-1:0] phaseTicks,
  input  logic              sdaIn,
  input  logic              sclIn,
  output logic              sdaDriveLow,
  output logic              sclDriveLow,
  output logic              flagClear,
  output logic              engineReset,
  output logic              done,
  output logic              fail
);

  recStrobes_t strb;
  logic busFree, phaseDone, attemptsSpent;

  bus_recovery_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .startReq     (startReq),
    .busFree      (busFree),
    .phaseDone    (phaseDone),
    .attemptsSpent(attemptsSpent),
    .strb         (strb),
    .flagClear    (flagClear),
    .engineReset  (engineReset)
  );

  bus_recovery_dp #(
    .MAX_ATTEMPTS(MAX_ATTEMPTS),
    .TICK_W      (TICK_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .tickIn       (tickIn),
    .phaseTicks   (phaseTicks),
    .sdaIn        (sdaIn),
    .sclIn        (sclIn),
    .busFree      (busFree),
    .phaseDone    (phaseDone),
    .attemptsSpent(attemptsSpent),
    .sclLow       (sclDriveLow),
    .doneQ        (done),
    .failQ        (fail)
  );

  // Data line is only ever released; a low here would fake a start condition.
  assign sdaDriveLow = 1'b0;

endmodule

// File: rtl/bus_recovery_chk.sv
module bus_recovery_chk (
  input logic clk,
  input logic rstN,
  input logic sdaIn,
  input logic sclIn,
  input logic sclDriveLow,
  input logic flagClear,
  input logic engineReset,
  input logic done,
  input logic fail
);

  a_r2_pull_under_reset: assert property (@(posedge clk) disable iff (!rstN)
    sclDriveLow |-> engineReset);

  a_r1_clear_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    flagClear |=> (!flagClear && engineReset));

  a_r7_result_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(done && fail));

  a_r5_pull_only_when_held: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclDriveLow) |-> !$past(sdaIn && sclIn));

  a_r3_done_only_when_free: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(sdaIn && sclIn));

  a_r2_release_with_result: assert property (@(posedge clk) disable iff (!rstN)
    $fell(engineReset) |-> (done || fail));

endmodule

bind bus_recovery_seq bus_recovery_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sdaIn      (sdaIn),
  .sclIn      (sclIn),
  .sclDriveLow(sclDriveLow),
  .flagClear  (flagClear),
  .engineReset(engineReset),
  .done       (done),
  .fail       (fail)
);

// File: tb/bus_recovery_seq_tb.sv
module bus_recovery_seq_tb;

  localparam int TICK_W  = 8;
  localparam int MAX_ATT = 100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic tickIn = 1'b0;
  logic [TICK_W-1:0] phaseTicks = 8'd1;
  logic sdaIn, sclIn;
  logic sdaDriveLow, sclDriveLow, flagClear, engineReset, done, fail;

  int total = 0;
  int bad = 0;
  int tickDiv = 1;
  int expTicks = 1;
  int pulses = 0;
  int curTicks = 0;
  int tickErr = 0;
  int clearPulses = 0;
  int sdaLowCycles = 0;
  int sdaRelAfter = 0;
  int sclRelAfter = 0;
  logic prevScl = 1'b0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  // Open-drain bus model: a line is high unless someone pulls it.
  assign sdaIn = !sdaDriveLow && !(pulses < sdaRelAfter);
  assign sclIn = !sclDriveLow && !(pulses < sclRelAfter);

  bus_recovery_seq #(.MAX_ATTEMPTS(MAX_ATT), .TICK_W(TICK_W)) u_dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .tickIn(tickIn),
    .phaseTicks(phaseTicks), .sdaIn(sdaIn), .sclIn(sclIn),
    .sdaDriveLow(sdaDriveLow), .sclDriveLow(sclDriveLow),
    .flagClear(flagClear), .engineReset(engineReset),
    .done(done), .fail(fail)
  );

  // Bit-period timer stand-in: one tick every tickDiv cycles.
  initial begin
    int divCnt = 0;
    forever begin
      @(posedge clk);
      divCnt = (divCnt + 1 >= tickDiv) ? 0 : divCnt + 1;
      tickIn <= (divCnt == 0);
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (sdaDriveLow) sdaLowCycles++;
      if (flagClear) clearPulses++;
      if (sclDriveLow && !prevScl) begin
        pulses++;
        curTicks = 0;
      end
      if (sclDriveLow && tickIn) curTicks++;
      if (!sclDriveLow && prevScl && curTicks != expTicks) tickErr++;
      prevScl = sclDriveLow;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setup(input int sdaK, input int sclK, input int ticks, input int div);
    @(negedge clk);
    sdaRelAfter = sdaK;
    sclRelAfter = sclK;
    phaseTicks  = TICK_W'(ticks);
    tickDiv     = div;
    expTicks    = (ticks == 0) ? 1 : ticks;
    pulses      = 0;
    tickErr     = 0;
    clearPulses = 0;
  endtask

  task automatic runStart();
    @(negedge clk);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    check(flagClear == 1'b1, "R1 flagClear after start", int'(flagClear), 1);
    check(engineReset == 1'b1, "R1 engineReset after start", int'(engineReset), 1);
    check(sclDriveLow == 1'b0 && sdaDriveLow == 1'b0, "R4 drivers released",
          int'({sclDriveLow, sdaDriveLow}), 0);
  endtask

  task automatic waitEnd(input string req);
    int n = 0;
    while (!(done || fail) && n < 20000) begin
      @(negedge clk);
      n++;
    end
    check(done || fail, req, n, -1);
    check(engineReset == 1'b0, "R2 reset released at end", int'(engineReset), 0);
  endtask

  task automatic t_reset();
    check(done == 1'b0 && fail == 1'b0, "R7 result clear after reset",
          int'({done, fail}), 0);
    check(engineReset == 1'b0, "R2 engineReset low after reset", int'(engineReset), 0);
    check(sclDriveLow == 1'b0 && flagClear == 1'b0, "R4 idle outputs",
          int'({sclDriveLow, flagClear}), 0);
  endtask

  task automatic t_freeBus();
    setup(0, 0, 2, 1);
    runStart();
    waitEnd("R3 free bus end");
    check(done == 1'b1 && fail == 1'b0, "R3 free bus done", int'({done, fail}), 2);
    check(pulses == 0, "R3 no pulse on free bus", pulses, 0);
  endtask

  task automatic t_sdaStuck();
    setup(3, 0, 3, 4);
    runStart();
    waitEnd("R5 stuck data end");
    check(done == 1'b1, "R5 stuck data done", int'(done), 1);
    check(pulses == 3, "R5 pulse count", pulses, 3);
    check(tickErr == 0, "R5 low phase tick width", tickErr, 0);
  endtask

  task automatic t_zeroTicks();
    setup(2, 0, 0, 2);
    runStart();
    waitEnd("R5 zero ticks end");
    check(pulses == 2, "R5 zero ticks pulse count", pulses, 2);
    check(tickErr == 0, "R5 zero ticks acts as one", tickErr, 0);
  endtask

  task automatic t_sclStuck();
    setup(0, 2, 1, 1);
    runStart();
    waitEnd("R9 stuck clock end");
    check(done == 1'b1 && fail == 1'b0, "R9 stuck clock done", int'({done, fail}), 2);
    check(pulses == 2, "R9 stuck clock pulses", pulses, 2);
  endtask

  task automatic t_neverFree();
    setup(1000000, 0, 1, 1);
    runStart();
    waitEnd("R6 never free end");
    check(fail == 1'b1 && done == 1'b0, "R6 fail flag", int'({done, fail}), 1);
    check(pulses == MAX_ATT, "R6 attempt limit", pulses, MAX_ATT);
    repeat (5) @(negedge clk);
    check(fail == 1'b1, "R7 fail held", int'(fail), 1);
  endtask

  task automatic t_restartClears();
    setup(0, 0, 1, 1);
    runStart();
    check(fail == 1'b0 && done == 1'b0, "R7 result cleared on start",
          int'({done, fail}), 0);
    waitEnd("R7 restart end");
    check(done == 1'b1 && fail == 1'b0, "R7 restart done", int'({done, fail}), 2);
  endtask

  task automatic t_startIgnored();
    setup(4, 0, 2, 2);
    runStart();
    repeat (3) begin
      repeat (5) @(negedge clk);
      startReq = 1'b1;
      @(negedge clk);
      startReq = 1'b0;
    end
    waitEnd("R1 busy start end");
    check(clearPulses == 1, "R1 start ignored while busy", clearPulses, 1);
    check(pulses == 4, "R1 pulse count unaffected", pulses, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_freeBus();
    t_sdaStuck();
    t_zeroTicks();
    t_sclStuck();
    t_neverFree();
    t_restartClears();
    t_startIgnored();
    check(sdaLowCycles == 0, "R8 data never driven", sdaLowCycles, 0);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule